// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the output raster timing of a video path from a pixel clock and the input horizontal and vertical sync. A pixel counter and a line counter restart on the leading edges of the input syncs. From their values, programmable windows make the output horizontal and vertical sync, the horizontal and vertical blanking, a horizontal reference and a display-enable window. Each input and each output sync has its own polarity control.

Every horizontal position is programmed as an 8-bit value in units of 8 pixels. Every vertical position is an 8-bit value in units of 4 lines. The horizontal total is assembled from an 8-bit high part and a 2-bit low part, and its least significant bit is always zero. A start value greater than its end value makes a window that wraps past the end of the line or frame.

The vertical total is not programmed. The block counts lines between input vsync leading edges and holds the most recent count for readback.

Top module: `raster_timing_gen`

## Requirements
- R1: With the horizontal total T = hTotalHi*8 + hTotalLo*2, and no input hsync edge, pixelCount steps by one each clock from 0 up to T-1 and then returns to 0.
- R2: Input hsync is active high when inHsPol=1 and active low when inHsPol=0. Suppose the clock edge E1 is the first edge that samples it active after an edge that sampled it inactive. Then pixelCount reads 0 after the next edge E2 and counts on from there.
- R3: lineCount advances by one at each line start, which is a return of pixelCount to 0 by wrap or by hsync restart. It saturates at 2047. A leading edge of input vsync (polarity set by inVsPol, same two-edge latency as R2) sets it to 0.
- R4: At each input vsync leading edge, vTotalMeas takes the number of lines counted since the previous one, which is lineCount+1 (saturating at 2047). It is 0 after reset until the first such edge.
- R5: A horizontal window with register values s and e is active when pixelCount is at least 8*s and below 8*e for s<=e. It is active when pixelCount is at least 8*s or below 8*e for s>e. It is never active for s=e. hBlank equals the horizontal blank window.
- R6: Vertical windows follow the rule of R5 on lineCount with positions 4*s and 4*e. vBlank equals the vertical blank window.
- R7: outHsync equals the horizontal sync window when outHsPol=1 and its inverse when outHsPol=0. outVsync relates to the vertical sync window and outVsPol in the same way.
- R8: hRef is high exactly when neither hBlank nor vBlank is high.
- R9: dispEn is high exactly when both the horizontal and the vertical capture windows are active.
- R10: When hsync and vsync leading edges are detected on the same clock edge, lineCount becomes 0 and not 1, and pixelCount becomes 0.
- R11: While rstN is low, pixelCount, lineCount and vTotalMeas are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inHsync | input | 1 | Input horizontal sync |
| inVsync | input | 1 | Input vertical sync |
| inHsPol | input | 1 | Input hsync polarity, 1 = active high |
| inVsPol | input | 1 | Input vsync polarity, 1 = active high |
| outHsPol | input | 1 | Output hsync polarity, 1 = active high |
| outVsPol | input | 1 | Output vsync polarity, 1 = active high |
| hCapStart | input | 8 | Horizontal capture start, units of 8 pixels |
| hCapEnd | input | 8 | Horizontal capture end, units of 8 pixels |
| hSyncStart | input | 8 | Horizontal sync start, units of 8 pixels |
| hSyncEnd | input | 8 | Horizontal sync end, units of 8 pixels |
| hBlankStart | input | 8 | Horizontal blank start, units of 8 pixels |
| hBlankEnd | input | 8 | Horizontal blank end, units of 8 pixels |
| hTotalHi | input | 8 | Horizontal total bits 10..3 |
| hTotalLo | input | 2 | Horizontal total bits 2..1 |
| vCapStart | input | 8 | Vertical capture start, units of 4 lines |
| vCapEnd | input | 8 | Vertical capture end, units of 4 lines |
| vSyncStart | input | 8 | Vertical sync start, units of 4 lines |
| vSyncEnd | input | 8 | Vertical sync end, units of 4 lines |
| vBlankStart | input | 8 | Vertical blank start, units of 4 lines |
| vBlankEnd | input | 8 | Vertical blank end, units of 4 lines |
| outHsync | output | 1 | Output horizontal sync |
| outVsync | output | 1 | Output vertical sync |
| hBlank | output | 1 | Horizontal blanking |
| vBlank | output | 1 | Vertical blanking |
| hRef | output | 1 | Horizontal reference, high outside blanking |
| dispEn | output | 1 | Capture/display-enable window |
| pixelCount | output | 11 | Pixel counter |
| lineCount | output | 11 | Line counter |
| vTotalMeas | output | 11 | Measured vertical total |

## Verification
Two events can land on the same clock edge: a line start, which advances the line counter, and a vsync leading edge, which clears it. The same holds for an hsync restart and a natural wrap of the pixel counter. The bench provokes the first case by driving hsync and vsync active on the same falling edge. It then expects lineCount to read 0, and the measured total to take the pre-edge count plus one. It provokes the second case with hsync periods both shorter and longer than the programmed total, so that some restarts cut a line short and others follow a wrap. All window outputs are judged every cycle against arithmetic on the bench's own expected counters.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int REG_W   = 8;
  localparam int HLO_W   = 2;
  localparam int H_LOG2  = 3;
  localparam int V_LOG2  = 2;
  localparam int CNT_W   = REG_W + HLO_W + 1;
  localparam int NWIN    = 3;
  localparam int WIN_CAP   = 0;
  localparam int WIN_SYNC  = 1;
  localparam int WIN_BLANK = 2;

  typedef struct packed {
    logic lineRestart;
    logic frameRestart;
  } rtgStrobe_t;
endpackage

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int W = 11
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] winStart,
  input  logic [W-1:0] winStop,
  output logic         active
);
  always_comb begin
    if (winStart <= winStop) active = (cnt >= winStart) && (cnt < winStop);
    else                     active = (cnt >= winStart) || (cnt < winStop);
  end
endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inHsync,
  input  logic       inVsync,
  input  logic       inHsPol,
  input  logic       inVsPol,
  output rtgStrobe_t strobe
);
  logic hAct, hActD, vAct, vActD;

  // Normalise to active-high, then detect the leading edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hAct  <= 1'b0;
      hActD <= 1'b0;
      vAct  <= 1'b0;
      vActD <= 1'b0;
    end else begin
      hAct  <= inHsync ~^ inHsPol;
      hActD <= hAct;
      vAct  <= inVsync ~^ inVsPol;
      vActD <= vAct;
    end
  end

  assign strobe.lineRestart  = hAct & ~hActD;
  assign strobe.frameRestart = vAct & ~vActD;
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  rtgStrobe_t                 strobe,
  input  logic [REG_W-1:0]           hTotalHi,
  input  logic [HLO_W-1:0]           hTotalLo,
  input  logic [NWIN-1:0][REG_W-1:0] hStartArr,
  input  logic [NWIN-1:0][REG_W-1:0] hStopArr,
  input  logic [NWIN-1:0][REG_W-1:0] vStartArr,
  input  logic [NWIN-1:0][REG_W-1:0] vStopArr,
  input  logic                       outHsPol,
  input  logic                       outVsPol,
  output logic                       outHsync,
  output logic                       outVsync,
  output logic                       hBlank,
  output logic                       vBlank,
  output logic                       hRef,
  output logic                       dispEn,
  output logic [CNT_W-1:0]           pixelCount,
  output logic [CNT_W-1:0]           lineCount,
  output logic [CNT_W-1:0]           vTotalMeas
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hTotal, hCnt, lCnt, meas;
  logic             hWrap, lineStart, lFull;
  logic [NWIN-1:0]  hWinAct, vWinAct;

  assign hTotal    = {hTotalHi, hTotalLo, 1'b0};
  assign hWrap     = (hCnt == hTotal - 1'b1);
  assign lineStart = strobe.lineRestart | hWrap;
  assign lFull     = (lCnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      lCnt <= '0;
      meas <= '0;
    end else begin
      hCnt <= lineStart ? '0 : hCnt + 1'b1;
      if (strobe.frameRestart) begin
        lCnt <= '0;
        meas <= lFull ? CNT_MAX : lCnt + 1'b1;
      end else if (lineStart && !lFull) begin
        lCnt <= lCnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : gWin
    logic [CNT_W-1:0] hS, hE, vS, vE;
    assign hS = CNT_W'({hStartArr[g], {H_LOG2{1'b0}}});
    assign hE = CNT_W'({hStopArr[g],  {H_LOG2{1'b0}}});
    assign vS = CNT_W'({vStartArr[g], {V_LOG2{1'b0}}});
    assign vE = CNT_W'({vStopArr[g],  {V_LOG2{1'b0}}});
    rtg_window #(.W(CNT_W)) uHWin (.cnt(hCnt), .winStart(hS), .winStop(hE), .active(hWinAct[g]));
    rtg_window #(.W(CNT_W)) uVWin (.cnt(lCnt), .winStart(vS), .winStop(vE), .active(vWinAct[g]));
  end

  assign outHsync   = hWinAct[WIN_SYNC] ~^ outHsPol;
  assign outVsync   = vWinAct[WIN_SYNC] ~^ outVsPol;
  assign hBlank     = hWinAct[WIN_BLANK];
  assign vBlank     = vWinAct[WIN_BLANK];
  assign hRef       = ~(hWinAct[WIN_BLANK] | vWinAct[WIN_BLANK]);
  assign dispEn     = hWinAct[WIN_CAP] & vWinAct[WIN_CAP];
  assign pixelCount = hCnt;
  assign lineCount  = lCnt;
  assign vTotalMeas = meas;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inHsync,
  input  logic             inVsync,
  input  logic             inHsPol,
  input  logic             inVsPol,
  input  logic             outHsPol,
  input  logic             outVsPol,
  input  logic [REG_W-1:0] hCapStart,
  input  logic [REG_W-1:0] hCapEnd,
  input  logic [REG_W-1:0] hSyncStart,
  input  logic [REG_W-1:0] hSyncEnd,
  input  logic [REG_W-1:0] hBlankStart,
  input  logic [REG_W-1:0] hBlankEnd,
  input  logic [REG_W-1:0] hTotalHi,
  input  logic [HLO_W-1:0] hTotalLo,
  input  logic [REG_W-1:0] vCapStart,
  input  logic [REG_W-1:0] vCapEnd,
  input  logic [REG_W-1:0] vSyncStart,
  input  logic [REG_W-1:0] vSyncEnd,
  input  logic [REG_W-1:0] vBlankStart,
  input  logic [REG_W-1:0] vBlankEnd,
  output logic             outHsync,
  output logic             outVsync,
  output logic             hBlank,
  output logic             vBlank,
  output logic             hRef,
  output logic             dispEn,
  output logic [CNT_W-1:0] pixelCount,
  output logic [CNT_W-1:0] lineCount,
  output logic [CNT_W-1:0] vTotalMeas
);
  rtgStrobe_t                 strobe;
  logic [NWIN-1:0][REG_W-1:0] hStartArr, hStopArr, vStartArr, vStopArr;

  assign hStartArr = {hBlankStart, hSyncStart, hCapStart};
  assign hStopArr  = {hBlankEnd,   hSyncEnd,   hCapEnd};
  assign vStartArr = {vBlankStart, vSyncStart, vCapStart};
  assign vStopArr  = {vBlankEnd,   vSyncEnd,   vCapEnd};

  rtg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inHsync(inHsync), .inVsync(inVsync),
    .inHsPol(inHsPol), .inVsPol(inVsPol), .strobe(strobe)
  );

  rtg_datapath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hTotalHi(hTotalHi), .hTotalLo(hTotalLo),
    .hStartArr(hStartArr), .hStopArr(hStopArr),
    .vStartArr(vStartArr), .vStopArr(vStopArr),
    .outHsPol(outHsPol), .outVsPol(outVsPol),
    .outHsync(outHsync), .outVsync(outVsync),
    .hBlank(hBlank), .vBlank(vBlank), .hRef(hRef), .dispEn(dispEn),
    .pixelCount(pixelCount), .lineCount(lineCount), .vTotalMeas(vTotalMeas)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] pixelCount,
  input logic [CNT_W-1:0] lineCount,
  input logic [CNT_W-1:0] vTotalMeas
);
  // R1, R2: any nonzero pixel count is the previous one plus one
  a_r1_pixel_step: assert property (@(posedge clk) disable iff (!rstN)
    (pixelCount != '0) |-> (pixelCount == $past(pixelCount) + 1'b1));

  // R3: the line count only clears or steps by one
  a_r3_line_step: assert property (@(posedge clk) disable iff (!rstN)
    (lineCount != $past(lineCount)) |->
      (lineCount == '0 || lineCount == $past(lineCount) + 1'b1));

  // R3: a line advance coincides with the pixel counter at zero
  a_r3_line_at_pixel_zero: assert property (@(posedge clk) disable iff (!rstN)
    (lineCount != $past(lineCount) && lineCount != '0) |-> (pixelCount == '0));

  // R4: the measured total changes only as the frame restarts
  a_r4_meas_at_frame: assert property (@(posedge clk) disable iff (!rstN)
    (vTotalMeas != $past(vTotalMeas)) |-> (lineCount == '0));

  // R4: a freshly measured total is never zero
  a_r4_meas_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (vTotalMeas != $past(vTotalMeas)) |-> (vTotalMeas != '0));
endmodule

bind raster_timing_gen rtg_checker uChk (
  .clk(clk), .rstN(rstN), .pixelCount(pixelCount),
  .lineCount(lineCount), .vTotalMeas(vTotalMeas)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inHsync = 1'b1, inVsync = 1'b1;
  logic inHsPol = 1'b0, inVsPol = 1'b0, outHsPol = 1'b0, outVsPol = 1'b0;
  logic [7:0] hCapStart, hCapEnd, hSyncStart, hSyncEnd, hBlankStart, hBlankEnd, hTotalHi;
  logic [1:0] hTotalLo;
  logic [7:0] vCapStart, vCapEnd, vSyncStart, vSyncEnd, vBlankStart, vBlankEnd;
  logic outHsync, outVsync, hBlank, vBlank, hRef, dispEn;
  logic [10:0] pixelCount, lineCount, vTotalMeas;

  int nChk = 0, nFail = 0;
  bit chkOn = 0, finished = 0;

  // Bench expectation state
  int hExp = 0, lExp = 0, measExp = 0;
  bit hq1 = 0, hq2 = 0, vq1 = 0, vq2 = 0, lastBoth = 0, lastH = 0;

  always #5 clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rstN(rstN), .inHsync(inHsync), .inVsync(inVsync),
    .inHsPol(inHsPol), .inVsPol(inVsPol), .outHsPol(outHsPol), .outVsPol(outVsPol),
    .hCapStart(hCapStart), .hCapEnd(hCapEnd), .hSyncStart(hSyncStart), .hSyncEnd(hSyncEnd),
    .hBlankStart(hBlankStart), .hBlankEnd(hBlankEnd), .hTotalHi(hTotalHi), .hTotalLo(hTotalLo),
    .vCapStart(vCapStart), .vCapEnd(vCapEnd), .vSyncStart(vSyncStart), .vSyncEnd(vSyncEnd),
    .vBlankStart(vBlankStart), .vBlankEnd(vBlankEnd),
    .outHsync(outHsync), .outVsync(outVsync), .hBlank(hBlank), .vBlank(vBlank),
    .hRef(hRef), .dispEn(dispEn), .pixelCount(pixelCount), .lineCount(lineCount),
    .vTotalMeas(vTotalMeas)
  );

  function automatic bit win(int c, int s, int e);
    if (s <= e) return (c >= s) && (c < e);
    return (c >= s) || (c < e);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected counters, updated at each rising edge from the requirements
  always @(posedge clk) begin : model
    bit hs, vs, ls;
    int tot;
    if (!rstN) begin
      hExp = 0; lExp = 0; measExp = 0;
      hq1 = 0; hq2 = 0; vq1 = 0; vq2 = 0; lastBoth = 0; lastH = 0;
    end else begin
      tot = hTotalHi * 8 + hTotalLo * 2;
      hs = hq1 && !hq2;
      vs = vq1 && !vq2;
      ls = hs || (hExp == tot - 1);
      if (vs) begin
        measExp = (lExp == 2047) ? 2047 : lExp + 1;
        lExp = 0;
      end else if (ls && lExp != 2047) begin
        lExp = lExp + 1;
      end
      hExp = ls ? 0 : hExp + 1;
      lastBoth = hs && vs;
      lastH = hs;
      hq2 = hq1; hq1 = inHsPol ? inHsync : !inHsync;
      vq2 = vq1; vq1 = inVsPol ? inVsync : !inVsync;
    end
  end

  always @(negedge clk) begin
    bit hw, vw;
    if (rstN && chkOn) begin
      chk(lastH ? "R2 pixelCount" : "R1 pixelCount", int'(pixelCount), hExp);
      chk(lastBoth ? "R10 lineCount" : "R3 lineCount", int'(lineCount), lExp);
      chk("R4 vTotalMeas", int'(vTotalMeas), measExp);
      chk("R5 hBlank", int'(hBlank), int'(win(hExp, hBlankStart * 8, hBlankEnd * 8)));
      chk("R6 vBlank", int'(vBlank), int'(win(lExp, vBlankStart * 4, vBlankEnd * 4)));
      hw = win(hExp, hSyncStart * 8, hSyncEnd * 8);
      vw = win(lExp, vSyncStart * 4, vSyncEnd * 4);
      chk("R7 outHsync", int'(outHsync), int'(outHsPol ? hw : !hw));
      chk("R7 outVsync", int'(outVsync), int'(outVsPol ? vw : !vw));
      chk("R8 hRef", int'(hRef),
          int'(!win(hExp, hBlankStart * 8, hBlankEnd * 8) && !win(lExp, vBlankStart * 4, vBlankEnd * 4)));
      chk("R9 dispEn", int'(dispEn),
          int'(win(hExp, hCapStart * 8, hCapEnd * 8) && win(lExp, vCapStart * 4, vCapEnd * 4)));
    end
  end

  task automatic setH(bit act); inHsync = act ? inHsPol : !inHsPol; endtask
  task automatic setV(bit act); inVsync = act ? inVsPol : !inVsPol; endtask
  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic doReset();
    chkOn = 0;
    rstN = 1'b0;
    setH(0); setV(0);
    cyc(3);
    chk("R11 reset pixelCount", int'(pixelCount), 0);
    chk("R11 reset lineCount", int'(lineCount), 0);
    chk("R11 reset vTotalMeas", int'(vTotalMeas), 0);
    rstN = 1'b1;
    chkOn = 1;
  endtask

  task automatic pulseV(int w);
    setV(1); cyc(w); setV(0);
  endtask

  initial begin
    // Scenario 1: total 26, wrapping sync/blank windows, negative polarities
    hTotalHi = 8'd3; hTotalLo = 2'd1;
    hCapStart = 8'd1; hCapEnd = 8'd2; hSyncStart = 8'd2; hSyncEnd = 8'd1;
    hBlankStart = 8'd3; hBlankEnd = 8'd1;
    vCapStart = 8'd1; vCapEnd = 8'd3; vSyncStart = 8'd0; vSyncEnd = 8'd1;
    vBlankStart = 8'd3; vBlankEnd = 8'd1;
    inHsPol = 0; inVsPol = 0; outHsPol = 0; outVsPol = 0;
    doReset();
    cyc(26 * 20 + 5);                         // R1, R3 free-running wrap
    for (int f = 0; f < 3; f++) begin         // R4 measured totals
      cyc(26 * (9 + f) + 7);
      pulseV(2);
    end
    cyc(40);

    // Scenario 2: positive polarities, early hsync restarts, coincident edges
    inHsPol = 1; inVsPol = 1; outHsPol = 1; outVsPol = 1;
    doReset();
    for (int ln = 0; ln < 40; ln++) begin     // R2, R10
      if (ln % 7 == 0) setV(1);
      setH(1); cyc(3); setH(0); setV(0); cyc(16);
    end
    for (int ln = 0; ln < 10; ln++) begin     // restart after a natural wrap
      setH(1); cyc(3); setH(0); cyc(27);
    end
    pulseV(3);
    cyc(60);

    // Scenario 3: total 40, empty windows (start equals end), mixed polarity
    hTotalHi = 8'd5; hTotalLo = 2'd0;
    hCapStart = 8'd2; hCapEnd = 8'd2; hSyncStart = 8'd4; hSyncEnd = 8'd1;
    hBlankStart = 8'd1; hBlankEnd = 8'd4;
    vCapStart = 8'd0; vCapEnd = 8'd2; vSyncStart = 8'd2; vSyncEnd = 8'd2;
    vBlankStart = 8'd2; vBlankEnd = 8'd0;
    inHsPol = 0; inVsPol = 0; outHsPol = 1; outVsPol = 0;
    doReset();
    cyc(40 * 15);
    pulseV(2);
    cyc(40 * 3);
    pulseV(4);
    cyc(50);

    chkOn = 0;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule